// File: doc/BRIEF.md
# Input Frame Neighbour Packer and Unpacker

This block builds the 32-bit words of an input capture memory from two live sources and takes them apart again on replay. The first source is a 20-bit link data word that arrives on every tick. The second is a 28-bit neighbour word that arrives once per 16-tick frame. The pack path places the link word in the low bits of every memory word. The neighbour word is cut into four 7-bit slices, and these go into a side field of the first four words of the frame, highest slice first. The other twelve words carry zero in that field.

Neighbour data may need to be recorded apart from the normal input data. For that case the pack path can take its neighbour slices from a replayed memory word instead of from the live neighbour input. The unpack path reads a replayed frame, passes the link data through, and rebuilds the 28-bit neighbour word once the fourth tick has been seen. It then raises a one-cycle strobe and holds the word until the next frame delivers a new one.

Top module: `nbr_frame_codec`

## Requirements
- R1: For every accepted pack word, bits 19..0 of `pk_word` equal `pk_link` of that tick, one clock after the tick.
- R2: With live neighbour source, the neighbour field (bits 26..20) of frame ticks 1, 2, 3 and 4 carries neighbour bits 27..21, 20..14, 13..7 and 6..0 respectively.
- R3: The neighbour field of ticks 5 to 16 is zero, and bits 31..27 of every packed word are zero.
- R4: The neighbour word and the source select are captured on the first tick of a frame; later changes of `pk_nbr` or `pk_nbr_live` inside that frame do not change the packed words.
- R5: A frame starts on any accepted tick with the start strobe, even in the middle of a frame. Without the strobe the tick count runs modulo 16, so the 17th tick starts a new frame and captures the neighbour word again. The start strobe is only looked at together with a valid tick.
- R6: When `pk_nbr_live` is low at frame start, the neighbour field of ticks 1 to 4 is copied from bits 26..20 of `pk_rep_word` on each tick. Link bits still come from `pk_link`, and all other bits of `pk_rep_word` are ignored.
- R7: `pk_word_vld` is high exactly one clock after each accepted tick. Cycles without `pk_valid` produce no output word and do not advance the tick count.
- R8: For every accepted replay word, `up_link` equals its bits 19..0, with `up_link_vld` high, one clock later. Bits 31..27 and the neighbour field of ticks 5 to 16 have no effect.
- R9: One clock after the fourth tick of a replayed frame is accepted, `up_nbr_vld` pulses for one cycle. At that point `up_nbr` holds the 28-bit word built from the four slices, first slice in the top bits, and it keeps that value until the next rebuild.
- R10: While in reset and right after it, all valid outputs are low and `pk_word`, `up_link` and `up_nbr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pk_valid | input | 1 | Pack tick valid |
| pk_sof | input | 1 | Pack frame start, qualified by `pk_valid` |
| pk_link | input | 20 | Link data of the tick |
| pk_nbr | input | 28 | Neighbour word of the frame |
| pk_nbr_live | input | 1 | 1: slices from `pk_nbr`; 0: slices from `pk_rep_word` |
| pk_rep_word | input | 32 | Replayed memory word supplying neighbour slices |
| pk_word | output | 32 | Packed memory word |
| pk_word_vld | output | 1 | Packed word valid |
| up_valid | input | 1 | Replay word valid |
| up_sof | input | 1 | Replay frame start, qualified by `up_valid` |
| up_word | input | 32 | Replayed memory word |
| up_link | output | 20 | Recovered link data |
| up_link_vld | output | 1 | Recovered link data valid |
| up_nbr | output | 28 | Rebuilt neighbour word |
| up_nbr_vld | output | 1 | One-cycle strobe on rebuild |

## Verification
The bench changes the neighbour input and the source select in the middle of a frame. A design that captured them on every tick would mix slices from two neighbour words. It runs frames past sixteen ticks without a start strobe and restarts frames early. A tick counter that saturates, or that ignores the strobe mid-frame, would then put slices on the wrong ticks. Replay frames arrive with all ones in the high bits and in the tail neighbour fields, so an unpacker that masks too little would corrupt the link data or the rebuilt word. Idle gaps inside frames catch a counter or an output valid that advances without a tick.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int unsigned LINK_W_DEF  = 20;
  localparam int unsigned SLICE_W_DEF = 7;
  localparam int unsigned NSLICE_DEF  = 4;
  localparam int unsigned FRAME_DEF   = 16;
  localparam int unsigned WORD_W_DEF  = 32;

  // Top bit of slice k when slices are sent highest first.
  function automatic int unsigned slice_top(input int unsigned k,
                                            input int unsigned nbr_w,
                                            input int unsigned slice_w);
    return nbr_w - 1 - k * slice_w;
  endfunction
endpackage

// File: rtl/nfc_rst_sync.sv
module nfc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      s1_q    <= 1'b1;
      rst_q_n <= s1_q;
    end
  end
endmodule

// File: rtl/nfc_tick_ctr.sv
module nfc_tick_ctr #(
  parameter int unsigned FRAME_LEN = nfc_pkg::FRAME_DEF,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             sof,
  output logic [CNT_W-1:0] idx
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    idx   = sof ? '0 : cnt_q;
    cnt_d = cnt_q;
    if (adv) begin
      if (idx == CNT_W'(FRAME_LEN - 1)) cnt_d = '0;
      else                              cnt_d = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nfc_packer.sv
module nfc_packer #(
  parameter int unsigned LINK_W    = nfc_pkg::LINK_W_DEF,
  parameter int unsigned SLICE_W   = nfc_pkg::SLICE_W_DEF,
  parameter int unsigned NSLICE    = nfc_pkg::NSLICE_DEF,
  parameter int unsigned FRAME_LEN = nfc_pkg::FRAME_DEF,
  parameter int unsigned WORD_W    = nfc_pkg::WORD_W_DEF,
  localparam int unsigned NBR_W    = SLICE_W * NSLICE,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_sof,
  input  logic [LINK_W-1:0]  in_link,
  input  logic [NBR_W-1:0]   in_nbr,
  input  logic               in_live,
  input  logic [SLICE_W-1:0] in_rep_slice,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_vld
);
  logic [CNT_W-1:0]   idx;
  logic               first;
  logic [NBR_W-1:0]   nbr_q, nbr_use;
  logic               live_q, live_use;
  logic [SLICE_W-1:0] slice;
  logic [WORD_W-1:0]  word_d;
  logic               cap_en;

  nfc_tick_ctr #(.FRAME_LEN(FRAME_LEN)) ctr_i (
    .clk (clk),
    .rst_n (rst_n),
    .adv (in_vld),
    .sof (in_sof),
    .idx (idx)
  );

  always_comb begin
    first    = (idx == '0);
    cap_en   = in_vld && first;
    nbr_use  = first ? in_nbr  : nbr_q;
    live_use = first ? in_live : live_q;
    slice    = '0;
    for (int k = 0; k < NSLICE; k++) begin
      if (idx == CNT_W'(k)) begin
        slice = live_use
              ? nbr_use[nfc_pkg::slice_top(k, NBR_W, SLICE_W) -: SLICE_W]
              : in_rep_slice;
      end
    end
    word_d = '0;
    word_d[LINK_W-1:0]         = in_link;
    word_d[LINK_W +: SLICE_W]  = slice;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbr_q    <= '0;
      live_q   <= 1'b0;
      out_word <= '0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_word <= word_d;
      if (cap_en) begin
        nbr_q  <= in_nbr;
        live_q <= in_live;
      end
    end
  end
endmodule

// File: rtl/nfc_unpacker.sv
module nfc_unpacker #(
  parameter int unsigned LINK_W    = nfc_pkg::LINK_W_DEF,
  parameter int unsigned SLICE_W   = nfc_pkg::SLICE_W_DEF,
  parameter int unsigned NSLICE    = nfc_pkg::NSLICE_DEF,
  parameter int unsigned FRAME_LEN = nfc_pkg::FRAME_DEF,
  localparam int unsigned NBR_W    = SLICE_W * NSLICE,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_sof,
  input  logic [LINK_W-1:0]  in_link,
  input  logic [SLICE_W-1:0] in_slice,
  output logic [LINK_W-1:0]  out_link,
  output logic               out_link_vld,
  output logic [NBR_W-1:0]   out_nbr,
  output logic               out_nbr_vld
);
  logic [CNT_W-1:0] idx;
  logic             in_side, last_slice;
  logic [NBR_W-1:0] acc_q, acc_d;

  nfc_tick_ctr #(.FRAME_LEN(FRAME_LEN)) ctr_i (
    .clk (clk),
    .rst_n (rst_n),
    .adv (in_vld),
    .sof (in_sof),
    .idx (idx)
  );

  always_comb begin
    in_side    = in_vld && (idx < CNT_W'(NSLICE));
    last_slice = in_vld && (idx == CNT_W'(NSLICE - 1));
    acc_d      = {acc_q[NBR_W-SLICE_W-1:0], in_slice};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      out_link     <= '0;
      out_link_vld <= 1'b0;
      out_nbr      <= '0;
      out_nbr_vld  <= 1'b0;
    end else begin
      out_link_vld <= in_vld;
      out_nbr_vld  <= last_slice;
      if (in_vld)     out_link <= in_link;
      if (in_side)    acc_q    <= acc_d;
      if (last_slice) out_nbr  <= acc_d;
    end
  end
endmodule

// File: rtl/nbr_frame_codec.sv
module nbr_frame_codec #(
  parameter int unsigned LINK_W    = nfc_pkg::LINK_W_DEF,
  parameter int unsigned SLICE_W   = nfc_pkg::SLICE_W_DEF,
  parameter int unsigned NSLICE    = nfc_pkg::NSLICE_DEF,
  parameter int unsigned FRAME_LEN = nfc_pkg::FRAME_DEF,
  parameter int unsigned WORD_W    = nfc_pkg::WORD_W_DEF,
  localparam int unsigned NBR_W    = SLICE_W * NSLICE,
  localparam int unsigned SIDE_HI  = LINK_W + SLICE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_valid,
  input  logic              pk_sof,
  input  logic [LINK_W-1:0] pk_link,
  input  logic [NBR_W-1:0]  pk_nbr,
  input  logic              pk_nbr_live,
  input  logic [WORD_W-1:0] pk_rep_word,
  output logic [WORD_W-1:0] pk_word,
  output logic              pk_word_vld,
  input  logic              up_valid,
  input  logic              up_sof,
  input  logic [WORD_W-1:0] up_word,
  output logic [LINK_W-1:0] up_link,
  output logic              up_link_vld,
  output logic [NBR_W-1:0]  up_nbr,
  output logic              up_nbr_vld
);
  logic rst_q_n;
  logic unused_bits;

  assign unused_bits = ^{pk_rep_word[WORD_W-1:SIDE_HI], pk_rep_word[LINK_W-1:0],
                         up_word[WORD_W-1:SIDE_HI]};

  nfc_rst_sync rst_i (
    .clk (clk),
    .rst_n (rst_n),
    .rst_q_n (rst_q_n)
  );

  nfc_packer #(
    .LINK_W (LINK_W), .SLICE_W (SLICE_W), .NSLICE (NSLICE),
    .FRAME_LEN (FRAME_LEN), .WORD_W (WORD_W)
  ) pack_i (
    .clk (clk),
    .rst_n (rst_q_n),
    .in_vld (pk_valid),
    .in_sof (pk_sof),
    .in_link (pk_link),
    .in_nbr (pk_nbr),
    .in_live (pk_nbr_live),
    .in_rep_slice (pk_rep_word[LINK_W +: SLICE_W]),
    .out_word (pk_word),
    .out_vld (pk_word_vld)
  );

  nfc_unpacker #(
    .LINK_W (LINK_W), .SLICE_W (SLICE_W), .NSLICE (NSLICE),
    .FRAME_LEN (FRAME_LEN)
  ) unpack_i (
    .clk (clk),
    .rst_n (rst_q_n),
    .in_vld (up_valid),
    .in_sof (up_sof),
    .in_link (up_word[LINK_W-1:0]),
    .in_slice (up_word[LINK_W +: SLICE_W]),
    .out_link (up_link),
    .out_link_vld (up_link_vld),
    .out_nbr (up_nbr),
    .out_nbr_vld (up_nbr_vld)
  );
endmodule

// File: rtl/nbr_frame_codec_chk.sv
module nbr_frame_codec_chk #(
  parameter int unsigned LINK_W  = 20,
  parameter int unsigned NBR_W   = 28,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SIDE_HI = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pk_valid,
  input logic [LINK_W-1:0] pk_link,
  input logic [WORD_W-1:0] pk_word,
  input logic              pk_word_vld,
  input logic              up_valid,
  input logic [WORD_W-1:0] up_word,
  input logic [LINK_W-1:0] up_link,
  input logic              up_link_vld,
  input logic [NBR_W-1:0]  up_nbr,
  input logic              up_nbr_vld
);
  assert_link_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid |=> pk_word[LINK_W-1:0] == $past(pk_link));

  assert_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pk_word_vld |-> pk_word[WORD_W-1:SIDE_HI] == '0);

  assert_vld_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid |=> pk_word_vld);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_valid |=> !pk_word_vld);

  assert_up_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (up_link_vld && up_link == $past(up_word[LINK_W-1:0])));

  assert_nbr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    up_nbr_vld |=> !up_nbr_vld);

  assert_nbr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_nbr_vld |-> $stable(up_nbr));
endmodule

bind nbr_frame_codec nbr_frame_codec_chk #(
  .LINK_W (LINK_W), .NBR_W (NBR_W), .WORD_W (WORD_W), .SIDE_HI (SIDE_HI)
) chk_i (
  .clk (clk),
  .rst_n (rst_q_n),
  .pk_valid (pk_valid),
  .pk_link (pk_link),
  .pk_word (pk_word),
  .pk_word_vld (pk_word_vld),
  .up_valid (up_valid),
  .up_word (up_word),
  .up_link (up_link),
  .up_link_vld (up_link_vld),
  .up_nbr (up_nbr),
  .up_nbr_vld (up_nbr_vld)
);

// File: tb/nbr_frame_codec_tb_top.sv
module nbr_frame_codec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pk_valid, pk_sof, pk_nbr_live;
  logic [19:0] pk_link;
  logic [27:0] pk_nbr;
  logic [31:0] pk_rep_word, pk_word;
  logic        pk_word_vld;
  logic        up_valid, up_sof;
  logic [31:0] up_word;
  logic [19:0] up_link;
  logic        up_link_vld;
  logic [27:0] up_nbr;
  logic        up_nbr_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] pk_exp_q[$];
  string       pk_tag_q[$];
  logic [19:0] lk_exp_q[$];
  logic [27:0] nb_exp_q[$];

  int          pk_idx = 0;
  logic [27:0] pk_lat;
  bit          pk_live_lat;
  int          up_idx = 0;
  logic [27:0] up_acc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_frame_codec dut_i (
    .clk (clk), .rst_n (rst_n),
    .pk_valid (pk_valid), .pk_sof (pk_sof), .pk_link (pk_link),
    .pk_nbr (pk_nbr), .pk_nbr_live (pk_nbr_live), .pk_rep_word (pk_rep_word),
    .pk_word (pk_word), .pk_word_vld (pk_word_vld),
    .up_valid (up_valid), .up_sof (up_sof), .up_word (up_word),
    .up_link (up_link), .up_link_vld (up_link_vld),
    .up_nbr (up_nbr), .up_nbr_vld (up_nbr_vld)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Slice k of a neighbour word, highest slice first (R2).
  function automatic logic [6:0] nslice(input logic [27:0] w, input int k);
    case (k)
      0: return w[27:21];
      1: return w[20:14];
      2: return w[13:7];
      default: return w[6:0];
    endcase
  endfunction

  task automatic pk_send(input bit sof, input logic [19:0] link, input logic [27:0] nbr,
                         input bit live, input logic [31:0] rep, input string tag);
    int idx;
    logic [6:0] sl;
    idx = sof ? 0 : pk_idx;
    if (idx == 0) begin
      pk_lat = nbr;
      pk_live_lat = live;
    end
    sl = '0;
    if (idx < 4) sl = pk_live_lat ? nslice(pk_lat, idx) : rep[26:20];
    pk_exp_q.push_back({5'b0, sl, link});
    pk_tag_q.push_back(idx < 4 ? {tag, " R2"} : {tag, " R3"});
    pk_idx = (idx + 1) % 16;
    @(posedge clk); #1;
    pk_valid = 1'b1; pk_sof = sof; pk_link = link;
    pk_nbr = nbr; pk_nbr_live = live; pk_rep_word = rep;
  endtask

  task automatic pk_idle();
    @(posedge clk); #1;
    pk_valid = 1'b0; pk_sof = 1'b1; pk_nbr = 28'hFFFFFFF;
    @(posedge clk); @(negedge clk);
    check(pk_word_vld == 1'b0, "R7 idle", {31'b0, pk_word_vld}, 32'h0);
  endtask

  task automatic up_send(input bit sof, input logic [31:0] w);
    int idx;
    idx = sof ? 0 : up_idx;
    lk_exp_q.push_back(w[19:0]);
    if (idx < 4) up_acc = {up_acc[20:0], w[26:20]};
    if (idx == 3) nb_exp_q.push_back(up_acc);
    up_idx = (idx + 1) % 16;
    @(posedge clk); #1;
    up_valid = 1'b1; up_sof = sof; up_word = w;
  endtask

  task automatic up_idle();
    @(posedge clk); #1;
    up_valid = 1'b0; up_sof = 1'b1; up_word = 32'hFFFFFFFF;
  endtask

  // Replay word: slice in side field for ticks 1-4, ones elsewhere in upper bits.
  function automatic logic [31:0] rp_word(input int t, input logic [27:0] n,
                                          input logic [19:0] l);
    logic [6:0] s;
    s = (t < 4) ? nslice(n, t) : 7'h7F;
    return {5'h1F, s, l};
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      if (pk_word_vld) begin
        if (pk_exp_q.size() == 0) check(1'b0, "R7 unexpected", pk_word, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = pk_exp_q.pop_front();
          t = pk_tag_q.pop_front();
          check(pk_word === e, {t, " R1"}, pk_word, e);
        end
      end
      if (up_link_vld) begin
        if (lk_exp_q.size() == 0) check(1'b0, "R8 unexpected", {12'b0, up_link}, 32'h0);
        else begin
          logic [19:0] e;
          e = lk_exp_q.pop_front();
          check(up_link === e, "R8", {12'b0, up_link}, {12'b0, e});
        end
      end
      if (up_nbr_vld) begin
        if (nb_exp_q.size() == 0) check(1'b0, "R9 unexpected", {4'b0, up_nbr}, 32'h0);
        else begin
          logic [27:0] e;
          e = nb_exp_q.pop_front();
          check(up_nbr === e, "R9", {4'b0, up_nbr}, {4'b0, e});
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pk_valid = 0; pk_sof = 0; pk_link = '0; pk_nbr = '0; pk_nbr_live = 1;
    pk_rep_word = '0; up_valid = 0; up_sof = 0; up_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pk_word_vld == 0 && up_link_vld == 0 && up_nbr_vld == 0, "R10 valids",
          {29'b0, pk_word_vld, up_link_vld, up_nbr_vld}, 32'h0);
    check(pk_word == 0, "R10 word", pk_word, 32'h0);
    check(up_nbr == 0 && up_link == 0, "R10 up", {4'b0, up_nbr}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pk_word_vld == 0 && up_nbr_vld == 0, "R10 after release",
          {30'b0, pk_word_vld, up_nbr_vld}, 32'h0);

    // Plain live frame.
    for (int i = 0; i < 16; i++)
      pk_send(i == 0, 20'(i * 20'h1111) ^ 20'hA5A5A, 28'hABCDEF1, 1'b1, 32'hFFFFFFFF, "R2");
    // Neighbour and source select change mid-frame, idle gaps inside.
    for (int i = 0; i < 16; i++) begin
      pk_send(i == 0, 20'(i * 20'h0F0F3), (i == 0) ? 28'h5A5A5A5 : 28'h0FFFFFF,
              (i == 0), 32'hFFFFFFFF, "R4");
      if (i % 3 == 2) pk_idle();
    end
    // No start strobe: count wraps and the neighbour word is taken again.
    for (int i = 0; i < 16; i++)
      pk_send(1'b0, 20'(i * 20'h2DA7), (i == 0) ? 28'h1234567 : 28'h7654321, 1'b1,
              32'h0, "R5 wrap");
    // Early restart at tick 6.
    for (int i = 0; i < 6; i++)
      pk_send(i == 0, 20'(i + 20'h00F00), 28'h0C3C3C3, 1'b1, 32'h0, "R5");
    for (int i = 0; i < 16; i++)
      pk_send(i == 0, 20'(i + 20'h77700), 28'hF0F0F0F, 1'b1, 32'h0, "R5 restart");
    // Replay source for the neighbour field.
    for (int i = 0; i < 16; i++)
      pk_send(i == 0, 20'(i * 20'h3333), 28'hFFFFFFF, (i != 0),
              32'(i * 32'h9E3779B9) | 32'h80000001, "R6");
    pk_idle();

    // Unpack: plain frame with garbage in unused bits.
    for (int i = 0; i < 16; i++)
      up_send(i == 0, rp_word(i, 28'h9ABCDEF, 20'(i * 20'h1357)));
    // Restart after three slices, with gaps.
    for (int i = 0; i < 3; i++)
      up_send(i == 0, rp_word(i, 28'h1111111, 20'(i)));
    for (int i = 0; i < 16; i++) begin
      up_send(i == 0, rp_word(i, 28'h2468ACE, 20'(i * 20'h0BEEF)));
      if (i == 1 || i == 2) up_idle();
    end
    // Wrap without strobe.
    for (int i = 0; i < 16; i++)
      up_send(1'b0, rp_word(i, 28'h0FEDCBA, 20'(i ^ 20'hFFFFF)));
    up_idle();
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(up_nbr == 28'h0FEDCBA, "R9 hold", {4'b0, up_nbr}, 32'h0FEDCBA);
    check(pk_exp_q.size() == 0, "R7 drained", pk_exp_q.size(), 0);
    check(lk_exp_q.size() == 0 && nb_exp_q.size() == 0, "R8 R9 drained",
          lk_exp_q.size() + nb_exp_q.size(), 0);
    finish_run();
  end
endmodule